// File: doc/BRIEF.md
# Gated Frequency Counter With Status

This block measures how often a single input signal rises, averaged over a programmable gate that lasts a whole number of seconds. The measured input is asynchronous. It passes through a synchroniser before its rising edges are counted while the gate is open. Seconds come from an external one-pulse-per-second reference; a parameter can instead derive them from a count of system clocks. When the gate closes, the edge count is divided by the gate length. The quotient is published in hertz with a valid flag, and the next gate opens in the same cycle. A missing reference raises an error flag. A result too wide for the output field raises an overrun flag.

Software drives the block through a plain register port with a control word at offset 0x0 and a status word at offset 0x4. Reads are combinational on the address.

A three-state controller sequences the work:
- `ST_OFF`: idle.
- `ST_GATE`: counting.
- `ST_CALC`: counting while the divider works.

Its transitions are:
- enable write: `ST_OFF` to `ST_GATE`.
- gate close: `ST_GATE` to `ST_CALC`.
- quotient done: `ST_CALC` to `ST_GATE`.
- reference timeout: `ST_GATE` or `ST_CALC` back to `ST_GATE`, restarting the gate.
- enabling write: any state to `ST_GATE`.
- disabling write: any state to `ST_OFF`.

The serial divider has its own three states, `DV_IDLE`, `DV_RUN` and `DV_DONE`, stepped as start, final bit, and hand-off.

Top module: `freq_meter`

## Requirements
- R1: The control word at offset 0x0 holds the enable in bit 0 and the gate length in seconds in bits 15:8. A write with bit 0 clear or a zero length stores zero. All other control bits read zero, a read of any offset other than 0x0 or 0x4 returns zero, and a length of 255 is kept.
- R2: After reset, both the control word and the status word read zero.
- R3: With a gate of N seconds, the result is the number of rising input edges between two gate-closing reference ticks, divided by N and rounded down. It is placed in status bits 23:0 with bit 31 (valid) set, no later than CNT_W+1 cycles after the closing tick.
- R4: A new gate opens at each gate close without software action, so a change of input frequency shows up in later results with no further write.
- R5: When the quotient does not fit in FREQ_W bits, or the edge accumulator overflows, status bit 29 (overrun) is set, bit 31 is clear and the value field is zero.
- R6: While enabled, a gap of TMO = 1.5 × CLKS_PER_SEC clocks without a reference tick sets status bit 30 (error) and restarts the gate. No error is raised before that gap has passed, and the flag clears when the next gate completes.
- R7: A write to the control word restarts the gate and clears the valid, error and overrun flags and the value field from the next cycle.
- R8: While disabled, reference ticks, input edges and missing ticks leave the status word at zero.
- R9: Status bits 28:24, and value bits at or above FREQ_W, always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal whose frequency is measured |
| pps_in | input | 1 | One-cycle-wide once-per-second reference tick, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A control write takes effect at the next clock edge, so the bench reads registers one cycle after the strobe. A measurement is published CNT_W+1 cycles after the gate-closing tick. The bench therefore reads status CNT_W+10 cycles after a tick, well before the next tick can disturb the value. It always waits for two complete gates after a write, so that the partial first second never reaches a compared result. The reference timeout becomes visible TMO cycles after the last tick. The bench brackets that point with one read at 250 cycles, which must show no error, and one at 320 cycles, which must show the flag.

// File: rtl/freq_meter_pkg.sv
`timescale 1ns/1ps
package freq_meter_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_GATE, ST_CALC} fm_state_e;
    typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_DONE} dv_state_e;

    localparam int REG_W        = 32;
    localparam int CTRL_OFS     = 0;
    localparam int STAT_OFS     = 4;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEC_LSB = 8;
    localparam int ST_VALID_BIT = 31;
    localparam int ST_ERR_BIT   = 30;
    localparam int ST_OVR_BIT   = 29;
    localparam int VALUE_W      = 24;
endpackage

// File: rtl/fm_edge_sync.sv
`timescale 1ns/1ps
module fm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    // sh[STAGES-1:0] is the synchroniser chain, sh[STAGES] the previous sample
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], sig_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R3: each input edge yields a single-cycle pulse
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fm_sec_source.sv
`timescale 1ns/1ps
module fm_sec_source #(
    parameter bit USE_EXT      = 1'b1,
    parameter int CLKS_PER_SEC = 125_000_000,
    parameter int TMO          = 187_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic ext_tick,
    output logic sec_tick,
    output logic timeout
);
    generate
        if (USE_EXT) begin : g_ext
            localparam int GW = $clog2(TMO + 1);
            logic [GW-1:0] gap;
            logic          gap_end;

            assign gap_end = (gap == GW'(TMO - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                       gap <= '0;
                else if (!run || restart || ext_tick || gap_end)  gap <= '0;
                else                                              gap <= gap + 1'b1;
            end

            assign sec_tick = run && ext_tick;
            assign timeout  = run && !restart && !ext_tick && gap_end;
        end else begin : g_int
            localparam int DW = $clog2(CLKS_PER_SEC + 1);
            logic [DW-1:0] div;
            logic          div_end;

            assign div_end = (div == DW'(CLKS_PER_SEC - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        div <= '0;
                else if (!run || restart || div_end) div <= '0;
                else                               div <= div + 1'b1;
            end

            assign sec_tick = run && !restart && div_end;
            assign timeout  = 1'b0;
        end
    endgenerate

    // R8: nothing leaves this block while measurement is off
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!sec_tick && !timeout));
endmodule

// File: rtl/fm_divider.sv
`timescale 1ns/1ps
module fm_divider
    import freq_meter_pkg::*;
#(
    parameter int N_W = 32,
    parameter int D_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           busy,
    output logic           done,
    output logic [N_W-1:0] quot
);
    localparam int SW = (N_W > 1) ? $clog2(N_W) : 1;

    dv_state_e      st, st_nxt;
    logic [N_W-1:0] n_sh, q_r;
    logic [D_W-1:0] d_r, rem;
    logic [SW-1:0]  step;
    logic [D_W:0]   trial, diff;
    logic           ge;

    assign trial = {rem, n_sh[N_W-1]};
    assign diff  = trial - {1'b0, d_r};
    assign ge    = (trial >= {1'b0, d_r});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DV_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            DV_IDLE: if (start) st_nxt = DV_RUN;
            DV_RUN:  if (step == SW'(N_W - 1)) st_nxt = DV_DONE;
            DV_DONE: st_nxt = DV_IDLE;
            default: st_nxt = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_sh <= '0;
            q_r  <= '0;
            d_r  <= '0;
            rem  <= '0;
            step <= '0;
        end else begin
            unique case (st)
                DV_IDLE: if (start) begin
                    n_sh <= num;
                    d_r  <= den;
                    rem  <= '0;
                    q_r  <= '0;
                    step <= '0;
                end
                DV_RUN: begin
                    rem  <= ge ? diff[D_W-1:0] : trial[D_W-1:0];
                    q_r  <= {q_r[N_W-2:0], ge};
                    n_sh <= {n_sh[N_W-2:0], 1'b0};
                    step <= step + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (st != DV_IDLE);
    assign done = (st == DV_DONE);
    assign quot = q_r;

    // R3: the finished remainder is smaller than the divisor
    assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < d_r));
    // R4: a gate never closes while the previous quotient is still in work
    assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == DV_IDLE));
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
    import freq_meter_pkg::*;
#(
    parameter bit USE_EXT_TICK = 1'b1,
    parameter int CLKS_PER_SEC = 125_000_000,
    parameter int CNT_W        = 32,
    parameter int FREQ_W       = 24,
    parameter int SEC_W        = 8,
    parameter int ADDR_W       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              pps_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int TMO = CLKS_PER_SEC + CLKS_PER_SEC / 2;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    fm_state_e      state, state_nxt;
    logic           ctrl_en;
    logic [SEC_W-1:0] ctrl_sec, new_sec, sec_cnt;
    logic           cfg_wr, new_on, running;
    logic           rise, sec_tick, timeout, gate_end, div_go, pub;
    logic           div_busy, div_done;
    logic [CNT_W-1:0] edge_cnt, edge_sat, quot;
    logic [CNT_W:0] edge_sum;
    logic           acc_ovf, snap_ovf, ovr_now;
    logic           f_valid, f_err, f_ovr;
    logic [FREQ_W-1:0] f_val;
    logic [REG_W-1:0] ctrl_word, stat_word;

    // ---------------- register port decode ----------------
    assign cfg_wr  = reg_wr && (reg_addr == A_CTRL);
    assign new_sec = reg_wdata[CTRL_SEC_LSB +: SEC_W];
    assign new_on  = reg_wdata[CTRL_EN_BIT] && (new_sec != '0);
    assign running = (state != ST_OFF);

    // ---------------- sub-blocks ----------------
    fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise   (rise)
    );

    fm_sec_source #(
        .USE_EXT      (USE_EXT_TICK),
        .CLKS_PER_SEC (CLKS_PER_SEC),
        .TMO          (TMO)
    ) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (cfg_wr),
        .ext_tick (pps_in),
        .sec_tick (sec_tick),
        .timeout  (timeout)
    );

    assign edge_sum = {1'b0, edge_cnt} + (CNT_W + 1)'(rise);
    assign edge_sat = edge_sum[CNT_W] ? '1 : edge_sum[CNT_W-1:0];
    assign gate_end = sec_tick && (sec_cnt == (ctrl_sec - SEC_W'(1)));
    assign div_go   = (state == ST_GATE) && gate_end && !cfg_wr && !timeout;
    assign pub      = (state == ST_CALC) && div_done && !cfg_wr && !timeout;

    fm_divider #(.N_W(CNT_W), .D_W(SEC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .num   (edge_sat),
        .den   (ctrl_sec),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (quot)
    );

    assign ovr_now = snap_ovf || (|quot[CNT_W-1:FREQ_W]);

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (cfg_wr && new_on) state_nxt = ST_GATE;
            end
            ST_GATE: begin
                if (cfg_wr)        state_nxt = new_on ? ST_GATE : ST_OFF;
                else if (timeout)  state_nxt = ST_GATE;
                else if (gate_end) state_nxt = ST_CALC;
            end
            ST_CALC: begin
                if (cfg_wr)        state_nxt = new_on ? ST_GATE : ST_OFF;
                else if (timeout)  state_nxt = ST_GATE;
                else if (div_done) state_nxt = ST_GATE;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // ---------------- datapath and published result ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_sec <= '0;
            sec_cnt  <= '0;
            edge_cnt <= '0;
            acc_ovf  <= 1'b0;
            snap_ovf <= 1'b0;
            f_valid  <= 1'b0;
            f_err    <= 1'b0;
            f_ovr    <= 1'b0;
            f_val    <= '0;
        end else if (cfg_wr) begin
            ctrl_en  <= new_on;
            ctrl_sec <= new_on ? new_sec : '0;
            sec_cnt  <= '0;
            edge_cnt <= '0;
            acc_ovf  <= 1'b0;
            snap_ovf <= 1'b0;
            f_valid  <= 1'b0;
            f_err    <= 1'b0;
            f_ovr    <= 1'b0;
            f_val    <= '0;
        end else if (timeout) begin
            sec_cnt  <= '0;
            edge_cnt <= '0;
            acc_ovf  <= 1'b0;
            f_err    <= 1'b1;
        end else if (running) begin
            if (gate_end) begin
                snap_ovf <= acc_ovf | edge_sum[CNT_W];
                edge_cnt <= '0;
                acc_ovf  <= 1'b0;
                sec_cnt  <= '0;
            end else begin
                if (sec_tick) sec_cnt <= sec_cnt + 1'b1;
                if (rise) begin
                    edge_cnt <= edge_sat;
                    if (edge_sum[CNT_W]) acc_ovf <= 1'b1;
                end
            end
            if (pub) begin
                f_valid <= !ovr_now;
                f_ovr   <= ovr_now;
                f_err   <= 1'b0;
                f_val   <= ovr_now ? '0 : quot[FREQ_W-1:0];
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_EN_BIT] = ctrl_en;
        ctrl_word[CTRL_SEC_LSB +: SEC_W] = ctrl_sec;
        stat_word = '0;
        stat_word[ST_VALID_BIT] = f_valid;
        stat_word[ST_ERR_BIT]   = f_err;
        stat_word[ST_OVR_BIT]   = f_ovr;
        stat_word[FREQ_W-1:0]   = f_val;
        if (reg_addr == A_CTRL)      reg_rdata = ctrl_word;
        else if (reg_addr == A_STAT) reg_rdata = stat_word;
        else                         reg_rdata = '0;
    end

    // ---------------- assertions ----------------
    // R7: a control write leaves every flag clear in the next cycle
    assert_flags_clear_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!f_valid && !f_err && !f_ovr));
    // R5: overrun and valid are never reported together
    assert_valid_excl_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_valid && f_ovr));
    // R8: while off and not written, the status word does not move
    assert_off_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !cfg_wr) |=> $stable(stat_word));
    // R6: the error flag can only rise while a measurement runs
    assert_err_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_err) |-> ($past(state) != ST_OFF));
    // R4: no gate closes while a quotient is being formed
    assert_gate_not_during_calc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |-> (!gate_end || cfg_wr || timeout || div_done));
    // R3: the divider is only busy while the controller waits for it
    assert_busy_matches_calc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATE && div_go) |=> div_busy);
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
    localparam int CPS = 200;
    localparam int CW  = 16;
    localparam int FW  = 6;
    localparam int NV  = 8;
    // half period of the input in clocks, gate seconds, expected hertz
    localparam int VH [NV] = '{2, 4, 3, 5, 10, 25, 100, 50};
    localparam int VN [NV] = '{1, 2, 3, 1, 3, 2, 1, 3};
    localparam int VF [NV] = '{50, 25, 33, 20, 10, 4, 1, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        pps_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int half = 2;
    int ph = 0;
    bit tick_on = 1'b1;
    bit finished = 1'b0;

    freq_meter #(
        .USE_EXT_TICK (1'b1),
        .CLKS_PER_SEC (CPS),
        .CNT_W        (CW),
        .FREQ_W       (FW),
        .SEC_W        (8),
        .ADDR_W       (4),
        .SYNC_STAGES  (2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .pps_in    (pps_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #4 clk = ~clk;

    initial begin : tick_gen
        forever begin
            @(negedge clk);
            ph = (ph == CPS - 1) ? 0 : ph + 1;
            pps_in = tick_on && (ph == 0);
        end
    end

    initial begin : sig_gen
        forever begin
            repeat (half) @(negedge clk);
            sig_in = ~sig_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!pps_in);
        end
    endtask

    task automatic settle();
        repeat (CW + 10) @(negedge clk);
    endtask

    function automatic logic [31:0] good(input int f);
        return 32'h8000_0000 | 32'(f);
    endfunction

    task automatic measure(input int h, input int n, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        half = h;
        wait_ticks(1);
        repeat (5) @(negedge clk);
        wr(4'h0, {16'h0, 8'(n), 8'h01});
        wait_ticks(2 * n);
        settle();
        rd(4'h4, d);
        check(tag, d, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of both words
        rd(4'h0, d); check("R2 control after reset", d, 32'h0);
        rd(4'h4, d); check("R2 status after reset", d, 32'h0);

        // R1: control layout, masking and off encodings
        wr(4'h0, 32'h0000_FF01); rd(4'h0, d); check("R1 length 255 kept", d, 32'h0000_FF01);
        wr(4'h0, 32'hFFFF_FF01); rd(4'h0, d); check("R1 unused control bits zero", d, 32'h0000_FF01);
        wr(4'h0, 32'h0000_0500); rd(4'h0, d); check("R1 enable clear stores zero", d, 32'h0);
        wr(4'h0, 32'h0000_0001); rd(4'h0, d); check("R1 zero length stores zero", d, 32'h0);
        rd(4'h8, d); check("R1 other offset reads zero", d, 32'h0);

        // R3: vector table of frequency and gate length
        for (int v = 0; v < NV; v++) begin
            measure(VH[v], VN[v], good(VF[v]), $sformatf("R3 vector %0d", v));
        end

        // R4: frequency change picked up with no new write
        measure(2, 1, good(50), "R4 base");
        half = 5;
        wait_ticks(3);
        settle();
        rd(4'h4, d); check("R4 follows new frequency", d, good(20));

        // R7: write clears flags and value at once
        wr(4'h0, 32'h0000_0101);
        rd(4'h4, d); check("R7 status cleared by write", d, 32'h0);

        // R6: missing reference
        half = 2;
        wait_ticks(3);
        settle();
        rd(4'h4, d); check("R6 running before gap", d, good(50));
        wait_ticks(1);
        tick_on = 1'b0;
        repeat (250) @(negedge clk);
        rd(4'h4, d); check("R6 no error before timeout", d, good(50));
        repeat (70) @(negedge clk);
        rd(4'h4, d); check("R6 error after timeout", d, 32'hC000_0032);
        tick_on = 1'b1;
        wait_ticks(2);
        settle();
        rd(4'h4, d); check("R6 error cleared by next gate", d, good(50));

        // R5 and R9: quotient too wide for FW bits
        measure(1, 1, 32'h2000_0000, "R5 overrun R9 upper bits zero");

        // R8: disabled block stays quiet
        wr(4'h0, 32'h0);
        rd(4'h0, d); check("R8 control off", d, 32'h0);
        wait_ticks(2);
        settle();
        rd(4'h4, d); check("R8 ticks ignored when off", d, 32'h0);
        tick_on = 1'b0;
        repeat (400) @(negedge clk);
        rd(4'h4, d); check("R8 no timeout when off", d, 32'h0);
        tick_on = 1'b1;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule